// File: doc/BRIEF.md
# Programmable Uncore Event Counter Bank

This block is a memory-mapped performance monitor for a cache-coherence home agent. It keeps sixteen free-running 48-bit counters. Each counter watches one line of a 256-line event vector, picked by an 8-bit code, and adds one in every cycle where that line pulses and counting is allowed. Counting is gated twice: a single global run bit starts or stops every armed counter together, and each counter also has an arm bit of its own.

When a counter rolls over from its top value to zero, it raises a sticky overflow flag. A mask register decides which flags reach the single level-sensitive interrupt line. Software clears flags by writing ones to a separate clear register. All state is reached through a plain register bus. Reads are combinational. Writes take effect at the clock edge on which the write strobe is high.

Top module: `evc_bank`

## Requirements
- R1: After reset, the run bit, the arm bits, the overflow flags and every counter read as zero. The mask register at 0x0804 reads 0xFFFF, and every select register reads 0xFFFFFFFF.
- R2: A counter adds one on each clock edge where the run bit (0x1E00 bit 0) is set, its arm bit (0x1E04 bit n) is set, and the event line named by its select code is high. Several counters may advance in the same cycle.
- R3: If either the run bit or the counter's arm bit is clear, the counter holds its value whatever the event lines do.
- R4: The select code of counter n lives in register 0x1E80 + 4·(n/4), bits [8·(n mod 4)+7 : 8·(n mod 4)], and reads back there. The code 0xFF selects nothing, so it never counts, even when event line 255 is high.
- R5: Counter n is at 0x1F00 + 8·n. Bits 47:0 hold the count. Bits 63:48 read as zero, and writes to them are dropped.
- R6: A counter at 2^48−1 that increments becomes zero and sets bit n of the flag register at 0x0808.
- R7: The interrupt output is high exactly when some flag bit n is set while mask bit n is 0. A mask bit of 1 hides that counter.
- R8: The flag register ignores writes. Writing 1 to bit n of 0x080C clears flag n, and zero bits leave flags alone. If a clear and a new overflow of the same counter fall in one cycle, the flag stays set.
- R9: A bus write to a counter in the same cycle as an increment of that counter wins. The counter takes the written value, and no overflow is flagged.
- R10: Reads of unmapped or misaligned offsets return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 256 | One-cycle event pulses, one line per event code |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Byte offset of the register accessed |
| bus_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| bus_rdata | output | 64 | Read data, zero when bus_rd is low |
| irq | output | 1 | Level interrupt, OR of unmasked overflow flags |

## Verification
The two collisions that matter both land on one counter in one cycle.

The first is a software write of a counter against an increment of the same counter. The bench raises the write strobe and the selected event line on the same falling edge, and then expects the written value with no added count.

The second is a write-one-to-clear of a flag against a fresh rollover of the same counter. The counter is preloaded to all ones, then the clear write and the event pulse are driven together. The flag must read back as set, the counter as zero, and the interrupt as high while that counter is unmasked.

// File: rtl/evc_pkg.sv
// Package: shared sizes and register offsets of the event counter bank.
// Assumes byte addressing on a 16-bit offset bus.
package evc_pkg;
    localparam int unsigned EVC_NUM_CNT = 16;
    localparam int unsigned EVC_CNT_W   = 48;
    localparam int unsigned EVC_EVT_W   = 256;
    localparam int unsigned EVC_ADDR_W  = 16;
    localparam int unsigned EVC_DATA_W  = 64;
    localparam int unsigned EVC_LANE_W  = 8;
    localparam int unsigned EVC_LANES   = 4;

    localparam int unsigned OFF_MASK  = 32'h0804;
    localparam int unsigned OFF_FLAG  = 32'h0808;
    localparam int unsigned OFF_CLR   = 32'h080C;
    localparam int unsigned OFF_RUN   = 32'h1E00;
    localparam int unsigned OFF_ARM   = 32'h1E04;
    localparam int unsigned OFF_SEL0  = 32'h1E80;
    localparam int unsigned OFF_CNT0  = 32'h1F00;
endpackage

// File: rtl/evc_counter.sv
// Module: one event counter.
// Counts the event line chosen by sel while run is high.
// A bus write has priority over an increment.
// Assumes EVT_W == 2**CODE_W; the all-ones code selects nothing.
module evc_counter #(
    parameter int unsigned CNT_W  = 48,
    parameter int unsigned CODE_W = 8,
    parameter int unsigned EVT_W  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] sel,
    input  logic [EVT_W-1:0]  evt,
    input  logic              wr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    localparam logic [CODE_W-1:0] NONE = '1;

    logic hit;

    // Decide whether this cycle adds one and whether that add rolls over.
    always_comb begin
        hit  = run && (sel != NONE) && evt[sel];
        wrap = hit && !wr && (&count);
    end

    // Count register: reset, software load, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (wr)
            count <= wdata;
        else if (hit)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/evc_irq.sv
// Module: sticky overflow flags and the interrupt line.
// Set wins over clear in the same cycle; irq is combinational from registers.
module evc_irq #(
    parameter int unsigned NUM_CNT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] wrap_vec,
    input  logic [NUM_CNT-1:0] clr_vec,
    input  logic [NUM_CNT-1:0] mask,
    output logic [NUM_CNT-1:0] status,
    output logic               irq
);
    // Flag register: clear on request, then OR in new rollovers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr_vec) | wrap_vec;
    end

    // Interrupt: any flag whose mask bit is zero.
    always_comb irq = |(status & ~mask);
endmodule

// File: rtl/evc_regfile.sv
// Module: register decode, configuration storage and read mux.
// Holds the run bit, arm bits, mask and per-counter select codes.
// Produces write strobes for counters and the clear vector for flags.
// Assumes NUM_CNT <= 32 and CODE_W <= 8.
module evc_regfile
    import evc_pkg::*;
#(
    parameter int unsigned NUM_CNT = 16,
    parameter int unsigned CNT_W   = 48,
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_val,
    input  logic [NUM_CNT-1:0]             status,
    output logic                           glob_en,
    output logic [NUM_CNT-1:0]             cnt_en,
    output logic [NUM_CNT-1:0]             mask,
    output logic [NUM_CNT-1:0][CODE_W-1:0] sel,
    output logic [NUM_CNT-1:0]             cnt_wr,
    output logic [NUM_CNT-1:0]             clr_vec,
    output logic [DATA_W-1:0]              bus_rdata
);
    localparam int unsigned SEL_REGS = (NUM_CNT + EVC_LANES - 1) / EVC_LANES;
    localparam int unsigned CIDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam int unsigned SIDX_W   = (SEL_REGS > 1) ? $clog2(SEL_REGS) : 1;
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFF_FLAG);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
    localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(OFF_RUN);
    localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'(OFF_ARM);
    localparam logic [ADDR_W-1:0] A_SEL0 = ADDR_W'(OFF_SEL0);
    localparam logic [ADDR_W-1:0] A_CNT0 = ADDR_W'(OFF_CNT0);
    localparam logic [ADDR_W-1:0] CNT_SPAN = ADDR_W'(8 * NUM_CNT);
    localparam logic [ADDR_W-1:0] SEL_SPAN = ADDR_W'(4 * SEL_REGS);

    logic              hit_mask, hit_flag, hit_clr, hit_run, hit_arm;
    logic              hit_cnt, hit_sel;
    logic [ADDR_W-1:0] off_cnt, off_sel;
    logic [CIDX_W-1:0] cnt_idx;
    logic [SIDX_W-1:0] sel_idx;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:32];

    // Address decode for single registers and the two arrays.
    always_comb begin
        hit_mask = (bus_addr == A_MASK);
        hit_flag = (bus_addr == A_FLAG);
        hit_clr  = (bus_addr == A_CLR);
        hit_run  = (bus_addr == A_RUN);
        hit_arm  = (bus_addr == A_ARM);
        off_cnt  = bus_addr - A_CNT0;
        off_sel  = bus_addr - A_SEL0;
        hit_cnt  = (bus_addr >= A_CNT0) && (off_cnt < CNT_SPAN) && (off_cnt[2:0] == 3'd0);
        hit_sel  = (bus_addr >= A_SEL0) && (off_sel < SEL_SPAN) && (off_sel[1:0] == 2'd0);
        cnt_idx  = off_cnt[3 +: CIDX_W];
        sel_idx  = off_sel[2 +: SIDX_W];
    end

    // Write strobes that leave this module: counter loads and flag clears.
    always_comb begin
        cnt_wr = '0;
        if (bus_wr && hit_cnt)
            cnt_wr[cnt_idx] = 1'b1;
        clr_vec = (bus_wr && hit_clr) ? bus_wdata[NUM_CNT-1:0] : '0;
    end

    // Configuration registers with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            cnt_en  <= '0;
            mask    <= '1;
            for (int n = 0; n < NUM_CNT; n++)
                sel[n] <= '1;
        end else if (bus_wr) begin
            if (hit_run)
                glob_en <= bus_wdata[0];
            if (hit_arm)
                cnt_en <= bus_wdata[NUM_CNT-1:0];
            if (hit_mask)
                mask <= bus_wdata[NUM_CNT-1:0];
            for (int n = 0; n < NUM_CNT; n++)
                if (hit_sel && (sel_idx == SIDX_W'(n / EVC_LANES)))
                    sel[n] <= bus_wdata[(n % EVC_LANES)*EVC_LANE_W +: CODE_W];
        end
    end

    // Read mux: zero for idle bus, unmapped offsets and write-only clear.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_run)
                bus_rdata[0] = glob_en;
            if (hit_arm)
                bus_rdata[NUM_CNT-1:0] = cnt_en;
            if (hit_mask)
                bus_rdata[NUM_CNT-1:0] = mask;
            if (hit_flag)
                bus_rdata[NUM_CNT-1:0] = status;
            if (hit_cnt)
                bus_rdata[CNT_W-1:0] = cnt_val[cnt_idx];
            if (hit_sel)
                for (int n = 0; n < NUM_CNT; n++)
                    if (sel_idx == SIDX_W'(n / EVC_LANES))
                        bus_rdata[(n % EVC_LANES)*EVC_LANE_W +: CODE_W] = sel[n];
        end
    end
endmodule

// File: rtl/evc_bank.sv
// Module: top of the event counter bank.
// Ties the register file, one counter per slot and the flag/interrupt logic.
// Assumes event pulses and bus signals are synchronous to clk.
module evc_bank
    import evc_pkg::*;
#(
    parameter int unsigned NUM_CNT = EVC_NUM_CNT,
    parameter int unsigned CNT_W   = EVC_CNT_W,
    parameter int unsigned EVT_W   = EVC_EVT_W,
    parameter int unsigned ADDR_W  = EVC_ADDR_W,
    parameter int unsigned DATA_W  = EVC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_pulse,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned CODE_W = $clog2(EVT_W);

    logic                           glob_en;
    logic [NUM_CNT-1:0]             cnt_en;
    logic [NUM_CNT-1:0]             mask;
    logic [NUM_CNT-1:0][CODE_W-1:0] sel;
    logic [NUM_CNT-1:0]             cnt_wr;
    logic [NUM_CNT-1:0]             clr_vec;
    logic [NUM_CNT-1:0]             wrap_vec;
    logic [NUM_CNT-1:0]             status;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_val;

    evc_regfile #(
        .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .CODE_W(CODE_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cnt_val(cnt_val), .status(status),
        .glob_en(glob_en), .cnt_en(cnt_en), .mask(mask), .sel(sel),
        .cnt_wr(cnt_wr), .clr_vec(clr_vec), .bus_rdata(bus_rdata)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        evc_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W), .EVT_W(EVT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .run(glob_en & cnt_en[n]),
            .sel(sel[n]),
            .evt(evt_pulse),
            .wr(cnt_wr[n]),
            .wdata(bus_wdata[CNT_W-1:0]),
            .count(cnt_val[n]),
            .wrap(wrap_vec[n])
        );
    end

    evc_irq #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .wrap_vec(wrap_vec), .clr_vec(clr_vec), .mask(mask),
        .status(status), .irq(irq)
    );
endmodule

// File: rtl/evc_bank_chk.sv
// Module: assertion checker bound into evc_bank.
// Observes bus, counters, rollover pulses, flags and interrupt.
module evc_bank_chk
    import evc_pkg::*;
#(
    parameter int unsigned NUM_CNT = 16,
    parameter int unsigned CNT_W   = 48,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          glob_en,
    input logic                          bus_wr,
    input logic                          bus_rd,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val,
    input logic [NUM_CNT-1:0]            wrap_vec,
    input logic [NUM_CNT-1:0]            status,
    input logic [NUM_CNT-1:0]            clr_vec,
    input logic                          irq
);
    localparam logic [ADDR_W-1:0] A_CNT0 = ADDR_W'(OFF_CNT0);
    localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(OFF_CNT0 + 8 * NUM_CNT);
    localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(OFF_MASK);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !bus_wr) |=> $stable(cnt_val));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_vec != '0) |=> ((status & $past(wrap_vec)) == $past(wrap_vec)));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec == '0) |=> ((status & $past(status)) == $past(status)));

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= A_CNT0 && bus_addr < A_END) |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr < A_LOW) |-> (bus_rdata == '0));

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_wrap
        assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_vec[n] |=> (cnt_val[n] == '0));
    end
endmodule

bind evc_bank evc_bank_chk #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .cnt_val(cnt_val), .wrap_vec(wrap_vec), .status(status), .clr_vec(clr_vec),
    .irq(irq)
);

// File: tb/tb_evc_bank.sv
`timescale 1ns/1ps
module tb_evc_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] evt_pulse = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [63:0]  bus_wdata = '0;
    logic [63:0]  bus_rdata;
    logic         irq;
    int           n_chk = 0;
    int           n_bad = 0;

    localparam logic [63:0] MAX48 = 64'h0000_FFFF_FFFF_FFFF;

    always #2 clk = ~clk;

    evc_bank dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [63:0] exp);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [255:0] v, input int cycles);
        @(negedge clk);
        evt_pulse = v;
        repeat (cycles) @(negedge clk);
        evt_pulse = '0;
    endtask

    function automatic logic [255:0] line(input int code);
        logic [255:0] v = '0;
        v[code] = 1'b1;
        return v;
    endfunction

    task automatic t_reset();
        rd_chk("R1 mask reset", 16'h0804, 64'hFFFF);
        rd_chk("R1 flag reset", 16'h0808, 64'h0);
        rd_chk("R1 run reset", 16'h1E00, 64'h0);
        rd_chk("R1 arm reset", 16'h1E04, 64'h0);
        rd_chk("R1 select reset", 16'h1E80, 64'hFFFF_FFFF);
        rd_chk("R1 counter reset", 16'h1F78, 64'h0);
        check("R1 irq reset", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_count();
        wr(16'h1E84, 64'hFFFF_42FF);
        wr(16'h1E8C, 64'hFF07_FFFF);
        rd_chk("R4 select readback", 16'h1E84, 64'hFFFF_42FF);
        wr(16'h1E04, 64'h4030);
        wr(16'h1E00, 64'h1);
        pulse(line(8'h42), 3);
        rd_chk("R2 counter5 three events", 16'h1F28, 64'd3);
        pulse(line(8'h42) | line(8'h07), 2);
        rd_chk("R2 counter5 joint", 16'h1F28, 64'd5);
        rd_chk("R4 counter14 lane2 of reg3", 16'h1F70, 64'd2);
        pulse(line(255), 4);
        rd_chk("R4 code FF never counts", 16'h1F20, 64'd0);
    endtask

    task automatic t_gate();
        wr(16'h1E00, 64'h0);
        pulse(line(8'h42), 4);
        rd_chk("R3 run bit clear holds", 16'h1F28, 64'd5);
        wr(16'h1E00, 64'h1);
        wr(16'h1E04, 64'h4000);
        pulse(line(8'h42) | line(8'h07), 2);
        rd_chk("R3 arm bit clear holds", 16'h1F28, 64'd5);
        rd_chk("R2 armed counter14 runs", 16'h1F70, 64'd4);
        wr(16'h1E04, 64'h4030);
    endtask

    task automatic t_slot();
        wr(16'h1F10, 64'hABCD_0000_0000_0010);
        rd_chk("R5 upper bits dropped", 16'h1F10, 64'h10);
    endtask

    task automatic t_wrap();
        wr(16'h1F28, MAX48 - 1);
        pulse(line(8'h42), 1);
        rd_chk("R6 top value", 16'h1F28, MAX48);
        rd_chk("R6 no flag before wrap", 16'h0808, 64'h0);
        pulse(line(8'h42), 1);
        rd_chk("R6 wrapped to zero", 16'h1F28, 64'h0);
        rd_chk("R6 flag set", 16'h0808, 64'h20);
        check("R7 masked irq low", {63'd0, irq}, 64'd0);
        wr(16'h0804, 64'hFFDF);
        check("R7 unmasked irq high", {63'd0, irq}, 64'd1);
        wr(16'h0808, 64'hFFFF);
        rd_chk("R8 flag register ignores writes", 16'h0808, 64'h20);
        wr(16'h080C, 64'h0001);
        rd_chk("R8 clear of other bit", 16'h0808, 64'h20);
        wr(16'h080C, 64'h0020);
        rd_chk("R8 clear bit5", 16'h0808, 64'h0);
        check("R7 irq drops after clear", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_write_vs_count();
        wr(16'h1F28, MAX48);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h1F28; bus_wdata = 64'd100;
        evt_pulse = line(8'h42);
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
        rd_chk("R9 write wins over increment", 16'h1F28, 64'd100);
        rd_chk("R9 no flag from lost wrap", 16'h0808, 64'h0);
    endtask

    task automatic t_clear_vs_wrap();
        wr(16'h1F28, MAX48);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h080C; bus_wdata = 64'h20;
        evt_pulse = line(8'h42);
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
        rd_chk("R8 new wrap beats clear", 16'h0808, 64'h20);
        rd_chk("R6 counter zero after collide", 16'h1F28, 64'h0);
        check("R7 irq with collision", {63'd0, irq}, 64'd1);
        wr(16'h080C, 64'h20);
    endtask

    task automatic t_unmapped();
        rd_chk("R10 unmapped low read", 16'h1234, 64'h0);
        rd_chk("R10 past last counter", 16'h1F80, 64'h0);
        rd_chk("R10 clear register reads zero", 16'h080C, 64'h0);
        wr(16'h1E08, '1);
        wr(16'h1F04, '1);
        wr(16'h0800, '1);
        rd_chk("R10 run bit unchanged", 16'h1E00, 64'h1);
        rd_chk("R10 mask unchanged", 16'h0804, 64'hFFDF);
        rd_chk("R10 counter0 unchanged", 16'h1F00, 64'h0);
        rd_chk("R10 misaligned read", 16'h1F04, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_gate();
        t_slot();
        t_wrap();
        t_write_vs_count();
        t_clear_vs_wrap();
        t_unmapped();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule